// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide register file that answers a handful of ISA-style I/O port addresses on a simple strobe bus. The bus has one shared address, a write strobe with write data, and a read strobe. The bank keeps a few writable control bits and drives them out as side-band levels: a soft reset, a little-endian mode flag, a disk activity light, a 4-bit system control field and an I/O map-mode select. Writes to two lock ports do not store anything. Each such write instead produces a single-clock toggle pulse for an external non-volatile memory's write lock.

Several ports return fixed identification, equipment and status bytes. Two ports form independent scratch bytes. The cache-invalidate port is accepted but has no effect. Any access to a port outside the decoded set reads as all ones and raises a one-cycle error pulse. Read data is registered: it appears in the cycle after the read strobe and then holds until the next read.

Top module: `sysctl_regbank`

## Requirements
- R1: A write to port 0x092 sets `soft_rst` from data bit 0 and `le_mode` from data bit 1, one clock after the write. Both outputs then hold until the next write to 0x092. A read of 0x092 always returns 0x00.
- R2: Reads of the fixed ports return these bytes: 0x800 → 0xEF, 0x802 → 0xAD, 0x803 → 0xE0, 0x80C → 0x3C, 0x810 → 0x39, 0x818 → 0x00, 0x823 → 0x03.
- R3: Writes to 0x800, 0x802 and 0x803 are accepted without error. They change neither any output nor any readback value.
- R4: A write to 0x808 sets `disk_led` from data bit 0, one clock after the write.
- R5: Each write to 0x810 gives exactly one single-clock high pulse on `nv_lock1_tgl`, in the cycle after the write. Each write to 0x812 does the same on `nv_lock2_tgl`. No other write pulses either output.
- R6: A write to 0x81C stores data bits 3:0 into `sys_ctrl`. A read of 0x81C returns that value in bits 3:0, with bits 7:4 reading zero.
- R7: A write to 0x850 stores data bit 0 into `io_map_sel`. A read of 0x850 returns it in bit 0, with the other bits zero.
- R8: Ports 0x398 and 0x399 are two independent 8-bit scratch bytes. Each reads back the last value written to it.
- R9: A read of any port outside {0x092, 0x398, 0x399, 0x800, 0x802, 0x803, 0x80C, 0x810, 0x814, 0x818, 0x81C, 0x823, 0x850} returns 0xFF. A read of 0x814 also returns 0xFF, and a write to 0x814 has no effect.
- R10: `bus_err` pulses high for one clock, the cycle after the access, when either of these occurs:
  - a read of a port outside the set in R9;
  - a write to a port outside {0x092, 0x398, 0x399, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C, 0x850}.
- R11: After reset, every stored bit, every output and `rd_data` are zero.
- R12: `rd_data` changes only in the cycle after `rd_en` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W (12) | Port address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle pulse on an access to an undecoded port |
| soft_rst | output | 1 | Soft reset level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity light |
| nv_lock1_tgl | output | 1 | Lock 1 toggle pulse |
| nv_lock2_tgl | output | 1 | Lock 2 toggle pulse |
| sys_ctrl | output | 4 | System control field |
| io_map_sel | output | 1 | I/O map-mode select |

## Verification
The bench builds the block with the default 12-bit address. At that width, every port number from 0x000 to 0xFFF can be visited, so it does exactly that: read sweeps before and after a full write sweep cover the whole address space.

Because every address is visited, each decode hole next to a live port is exercised. This includes the write-only port 0x812, the read-only ports 0x80C, 0x818 and 0x823, and the silent 0x814. The write sweep uses address-derived data, so each control output is checked after every write against a model held in the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int BYTE_W = 8;
  localparam int PORT_W = 12;
  localparam int CTRL_W = 4;
  localparam int SCR_N  = 2;

  localparam logic [PORT_W-1:0] P_RSTEND = 12'h092;
  localparam logic [PORT_W-1:0] P_SCR0   = 12'h398;
  localparam logic [PORT_W-1:0] P_CPUCFG = 12'h800;
  localparam logic [PORT_W-1:0] P_FEAT   = 12'h802;
  localparam logic [PORT_W-1:0] P_STAT   = 12'h803;
  localparam logic [PORT_W-1:0] P_LIGHT  = 12'h808;
  localparam logic [PORT_W-1:0] P_EQUIP  = 12'h80C;
  localparam logic [PORT_W-1:0] P_LOCK1  = 12'h810;
  localparam logic [PORT_W-1:0] P_LOCK2  = 12'h812;
  localparam logic [PORT_W-1:0] P_INVAL  = 12'h814;
  localparam logic [PORT_W-1:0] P_KEY    = 12'h818;
  localparam logic [PORT_W-1:0] P_CTRL   = 12'h81C;
  localparam logic [PORT_W-1:0] P_CACHE  = 12'h823;
  localparam logic [PORT_W-1:0] P_MAP    = 12'h850;

  localparam logic [BYTE_W-1:0] V_CPUCFG = 8'hEF;
  localparam logic [BYTE_W-1:0] V_FEAT   = 8'hAD;
  localparam logic [BYTE_W-1:0] V_STAT   = 8'hE0;
  localparam logic [BYTE_W-1:0] V_EQUIP  = 8'h3C;
  localparam logic [BYTE_W-1:0] V_EXTF   = 8'h39;
  localparam logic [BYTE_W-1:0] V_KEY    = 8'h00;
  localparam logic [BYTE_W-1:0] V_CACHE  = 8'h03;
  localparam logic [BYTE_W-1:0] V_OPEN   = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RSTEND, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LIGHT,
    SEL_EQUIP, SEL_LOCK1, SEL_LOCK2, SEL_INVAL, SEL_KEY, SEL_CTRL,
    SEL_CACHE, SEL_MAP, SEL_SCR0, SEL_SCR1
  } port_sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel,
  output logic              rd_hit,
  output logic              wr_hit
);
  localparam int CW = (ADDR_W > PORT_W) ? ADDR_W : PORT_W;

  logic [CW-1:0] a_ext;
  assign a_ext = CW'(addr);

  always_comb begin
    sel = SEL_NONE;
    if      (a_ext == CW'(P_RSTEND)) sel = SEL_RSTEND;
    else if (a_ext == CW'(P_CPUCFG)) sel = SEL_CPUCFG;
    else if (a_ext == CW'(P_FEAT))   sel = SEL_FEAT;
    else if (a_ext == CW'(P_STAT))   sel = SEL_STAT;
    else if (a_ext == CW'(P_LIGHT))  sel = SEL_LIGHT;
    else if (a_ext == CW'(P_EQUIP))  sel = SEL_EQUIP;
    else if (a_ext == CW'(P_LOCK1))  sel = SEL_LOCK1;
    else if (a_ext == CW'(P_LOCK2))  sel = SEL_LOCK2;
    else if (a_ext == CW'(P_INVAL))  sel = SEL_INVAL;
    else if (a_ext == CW'(P_KEY))    sel = SEL_KEY;
    else if (a_ext == CW'(P_CTRL))   sel = SEL_CTRL;
    else if (a_ext == CW'(P_CACHE))  sel = SEL_CACHE;
    else if (a_ext == CW'(P_MAP))    sel = SEL_MAP;
    else if (a_ext == CW'(P_SCR0))   sel = SEL_SCR0;
    else if (a_ext == CW'(P_SCR0) + CW'(1)) sel = SEL_SCR1;
  end

  // Lock 2 has no read side; equipment, keylock and cache ports have no write side.
  always_comb begin
    rd_hit = (sel != SEL_NONE) && (sel != SEL_LIGHT) && (sel != SEL_LOCK2);
    wr_hit = (sel != SEL_NONE) && (sel != SEL_EQUIP) &&
             (sel != SEL_KEY)  && (sel != SEL_CACHE);
  end
endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  port_sel_e         sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              soft_rst_q,
  output logic              endian_q,
  output logic              light_q,
  output logic              lock1_q,
  output logic              lock2_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              map_q,
  output logic [BYTE_W-1:0] scr_q [SCR_N]
);
  logic              soft_rst_n, endian_n, light_n, lock1_n, lock2_n, map_n;
  logic [CTRL_W-1:0] ctrl_n;

  always_comb begin
    soft_rst_n = soft_rst_q;
    endian_n   = endian_q;
    light_n    = light_q;
    ctrl_n     = ctrl_q;
    map_n      = map_q;
    lock1_n    = 1'b0;
    lock2_n    = 1'b0;
    if (wr_stb) begin
      case (sel)
        SEL_RSTEND: begin
          soft_rst_n = wdata[0];
          endian_n   = wdata[1];
        end
        SEL_LIGHT: light_n = wdata[0];
        SEL_LOCK1: lock1_n = 1'b1;
        SEL_LOCK2: lock2_n = 1'b1;
        SEL_CTRL:  ctrl_n  = wdata[CTRL_W-1:0];
        SEL_MAP:   map_n   = wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_q <= 1'b0;
      endian_q   <= 1'b0;
      light_q    <= 1'b0;
      lock1_q    <= 1'b0;
      lock2_q    <= 1'b0;
      ctrl_q     <= '0;
      map_q      <= 1'b0;
    end else begin
      soft_rst_q <= soft_rst_n;
      endian_q   <= endian_n;
      light_q    <= light_n;
      lock1_q    <= lock1_n;
      lock2_q    <= lock2_n;
      ctrl_q     <= ctrl_n;
      map_q      <= map_n;
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    logic scr_we;
    assign scr_we = wr_stb && (sel == port_sel_e'(int'(SEL_SCR0) + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      scr_q[g] <= '0;
      else if (scr_we) scr_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  port_sel_e         sel,
  input  logic              rd_hit,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              map_q,
  input  logic [BYTE_W-1:0] scr_q [SCR_N],
  output logic [BYTE_W-1:0] rd_byte
);
  always_comb begin
    rd_byte = V_OPEN;
    if (rd_hit) begin
      case (sel)
        SEL_RSTEND: rd_byte = '0;
        SEL_CPUCFG: rd_byte = V_CPUCFG;
        SEL_FEAT:   rd_byte = V_FEAT;
        SEL_STAT:   rd_byte = V_STAT;
        SEL_EQUIP:  rd_byte = V_EQUIP;
        SEL_LOCK1:  rd_byte = V_EXTF;
        SEL_KEY:    rd_byte = V_KEY;
        SEL_CTRL:   rd_byte = BYTE_W'(ctrl_q);
        SEL_CACHE:  rd_byte = V_CACHE;
        SEL_MAP:    rd_byte = BYTE_W'(map_q);
        SEL_SCR0:   rd_byte = scr_q[0];
        SEL_SCR1:   rd_byte = scr_q[1];
        default:    rd_byte = V_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              bus_err,
  output logic              soft_rst,
  output logic              le_mode,
  output logic              disk_led,
  output logic              nv_lock1_tgl,
  output logic              nv_lock2_tgl,
  output logic [3:0]        sys_ctrl,
  output logic              io_map_sel
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  port_sel_e         sel;
  logic              rd_hit, wr_hit;
  logic [BYTE_W-1:0] scr_q [SCR_N];
  logic [BYTE_W-1:0] rd_byte;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .sel    (sel),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  sysctl_state u_st (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_stb     (wr_en),
    .sel        (sel),
    .wdata      (wr_data),
    .soft_rst_q (soft_rst),
    .endian_q   (le_mode),
    .light_q    (disk_led),
    .lock1_q    (nv_lock1_tgl),
    .lock2_q    (nv_lock2_tgl),
    .ctrl_q     (sys_ctrl),
    .map_q      (io_map_sel),
    .scr_q      (scr_q)
  );

  sysctl_rdmux u_mux (
    .sel     (sel),
    .rd_hit  (rd_hit),
    .ctrl_q  (sys_ctrl),
    .map_q   (io_map_sel),
    .scr_q   (scr_q),
    .rd_byte (rd_byte)
  );

  logic [BYTE_W-1:0] rd_q;
  logic              err_q, err_n;

  assign err_n = (rd_en && !rd_hit) || (wr_en && !wr_hit);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_byte;
      err_q <= err_n;
    end
  end

  assign rd_data = rd_q;
  assign bus_err = err_q;
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              bus_err,
  input logic              le_mode,
  input logic              nv_lock1_tgl,
  input logic              nv_lock2_tgl
);
  // R5
  lock1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_lock1_tgl |-> $past(wr_en && addr == ADDR_W'(12'h810)));
  // R5
  lock2_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_lock2_tgl |-> $past(wr_en && addr == ADDR_W'(12'h812)));
  // R5
  lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_lock1_tgl && nv_lock2_tgl));
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(rd_en || wr_en));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rd_data));
  // R1
  endian_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(le_mode));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .bus_err      (bus_err),
  .le_mode      (le_mode),
  .nv_lock1_tgl (nv_lock1_tgl),
  .nv_lock2_tgl (nv_lock2_tgl)
);

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr_en, rd_en;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic          bus_err, soft_rst, le_mode, disk_led, nv_lock1_tgl, nv_lock2_tgl, io_map_sel;
  logic [3:0]    sys_ctrl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sysctl_regbank #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bus_err(bus_err), .soft_rst(soft_rst),
    .le_mode(le_mode), .disk_led(disk_led), .nv_lock1_tgl(nv_lock1_tgl),
    .nv_lock2_tgl(nv_lock2_tgl), .sys_ctrl(sys_ctrl), .io_map_sel(io_map_sel)
  );

  // bench model of stored state
  logic       m_rst, m_end, m_led, m_map;
  logic [3:0] m_ctrl;
  logic [7:0] m_s0, m_s1;

  function automatic logic [7:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h092: return 8'h00;
      12'h800: return 8'hEF;
      12'h802: return 8'hAD;
      12'h803: return 8'hE0;
      12'h80C: return 8'h3C;
      12'h810: return 8'h39;
      12'h818: return 8'h00;
      12'h81C: return {4'h0, m_ctrl};
      12'h823: return 8'h03;
      12'h850: return {7'h0, m_map};
      12'h398: return m_s0;
      12'h399: return m_s1;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit rd_ok(input logic [11:0] a);
    case (a)
      12'h092, 12'h398, 12'h399, 12'h800, 12'h802, 12'h803, 12'h80C,
      12'h810, 12'h814, 12'h818, 12'h81C, 12'h823, 12'h850: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit wr_ok(input logic [11:0] a);
    case (a)
      12'h092, 12'h398, 12'h399, 12'h800, 12'h802, 12'h803, 12'h808,
      12'h810, 12'h812, 12'h814, 12'h81C, 12'h850: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [7:0] d);
    case (a)
      12'h092: begin m_rst = d[0]; m_end = d[1]; end
      12'h808: m_led = d[0];
      12'h81C: m_ctrl = d[3:0];
      12'h850: m_map = d[0];
      12'h398: m_s0 = d;
      12'h399: m_s1 = d;
      default: ;
    endcase
  endtask

  task automatic check_outs(input string req);
    chk({req, " soft_rst"}, 32'(soft_rst), 32'(m_rst));
    chk({req, " le_mode"}, 32'(le_mode), 32'(m_end));
    chk({req, " disk_led"}, 32'(disk_led), 32'(m_led));
    chk({req, " sys_ctrl"}, 32'(sys_ctrl), 32'(m_ctrl));
    chk({req, " io_map_sel"}, 32'(io_map_sel), 32'(m_map));
  endtask

  task automatic do_rd(input logic [11:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(a == 12'h092 ? "R1 rd" : (rd_ok(a) ? "R2/R6/R7/R8 rd" : "R9 rd"),
        32'(rd_data), 32'(exp_rd(a)));
    chk("R10 rd err", 32'(bus_err), 32'(!rd_ok(a)));
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
    chk("R10 wr err", 32'(bus_err), 32'(!wr_ok(a)));
    chk("R5 lock1 pulse", 32'(nv_lock1_tgl), 32'(a == 12'h810));
    chk("R5 lock2 pulse", 32'(nv_lock2_tgl), 32'(a == 12'h812));
    check_outs("R1/R3/R4/R6/R7");
    @(negedge clk);
    chk("R5 lock1 single", 32'(nv_lock1_tgl), 32'd0);
    chk("R5 lock2 single", 32'(nv_lock2_tgl), 32'd0);
    chk("R10 err single", 32'(bus_err), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    m_rst = 0; m_end = 0; m_led = 0; m_map = 0; m_ctrl = '0; m_s0 = '0; m_s1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 rd_data", 32'(rd_data), 32'd0);
    chk("R11 bus_err", 32'(bus_err), 32'd0);
    chk("R11 locks", 32'({nv_lock1_tgl, nv_lock2_tgl}), 32'd0);
    check_outs("R11");
    do_rd(12'h398);
    do_rd(12'h399);
    do_rd(12'h81C);

    // R9/R10/R2: full read sweep at reset values
    for (int a = 0; a < (1 << AW); a++) do_rd(12'(a));

    // R1 specific patterns
    do_wr(12'h092, 8'h01);
    do_wr(12'h092, 8'h02);
    do_wr(12'h092, 8'h03);
    do_wr(12'h092, 8'h00);
    // R8 independence
    do_wr(12'h398, 8'hA5);
    do_wr(12'h399, 8'h3C);
    do_rd(12'h398);
    do_rd(12'h399);
    // R6 upper bits dropped
    do_wr(12'h81C, 8'hFA);
    do_rd(12'h81C);
    // R12 hold
    @(negedge clk);
    chk("R12 rd hold", 32'(rd_data), 32'h0A);
    // R5 back-to-back lock writes
    do_wr(12'h810, 8'h00);
    do_wr(12'h812, 8'h00);
    // R3 ignored writes to ID ports
    do_wr(12'h800, 8'h00);
    do_wr(12'h802, 8'h11);
    do_wr(12'h803, 8'hFF);
    do_rd(12'h800);
    do_rd(12'h802);
    do_rd(12'h803);
    // R9 cache-invalidate write is silent
    do_wr(12'h814, 8'hFF);
    do_rd(12'h814);

    // full write sweep with address-derived data
    for (int a = 0; a < (1 << AW); a++) do_wr(12'(a), 8'(a * 37 + 11));
    // read sweep after writes
    for (int a = 0; a < (1 << AW); a++) do_rd(12'(a));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule